// File: doc/BRIEF.md
# ADC Sample Buffer Writer

The block takes corrected 16-bit samples from an ADC, one per valid pulse, and stores them in a RAM buffer through a one-cycle memory write port. Before the channel starts, it is given a byte start address and a buffer length counted in samples. A channel reset pulse puts the channel in idle. A load pulse then starts it in one of two modes. In linear mode the channel fills the buffer once and then stops. In circular mode the pointer returns to the start after the last slot, and writing continues.

The block raises three sticky flags: lower half filled, whole buffer filled, and a sample that arrived after a linear pass had finished. Each flag is cleared by its own write-one-to-clear bit. The address of the next slot to be written is always visible on `cur_addr_o`.

Top module: `adc_dma_writer`

## Requirements
- R1: An accepted sample is written one cycle later with `mem_we_o`=1. The write address is the latched start address with bit 0 forced to 0, plus twice the sample index, modulo 2^ADDR_W. The data is passed through unchanged.
- R2: A `chan_rst_i` pulse returns the channel to idle and clears the sample index. `cur_addr_o` then equals the latched start address, and `mem_we_o` stays low in the next cycle. An async reset clears all outputs to 0.
- R3: A `chan_load_i` pulse starts the channel only if all of these hold: the channel is idle, `cfg_len_i` is nonzero, and `adc_en_i` is high. At start the channel latches the start address, the length and `cfg_wrap_i` (0 = linear, 1 = circular). A load pulse while running or stopped is ignored.
- R4: The half flag (`flag_half_o`) is set when the write of sample index floor(len/2)-1 is accepted. For len=1 it never fires.
- R5: The full flag (`flag_full_o`) is set when the write of the last slot (index len-1) is accepted.
- R6: In linear mode exactly len samples are written. After that the channel is stopped, and later samples produce no write.
- R7: A sample that arrives while a linear channel is stopped sets the overflow flag (`flag_ovf_o`) and produces no write.
- R8: In circular mode, after the last slot the index returns to 0 and writing continues. The half and full flags are raised again on every pass. The overflow flag never rises in this mode.
- R9: `cur_addr_o` shows the address of the next slot. For a stopped linear channel it shows start + 2*len.
- R10: The flags are sticky. `flag_clr_i` bit 0 clears half, bit 1 clears full and bit 2 clears overflow. If a set and a clear hit the same flag in the same cycle, the flag is set.
- R11: A sample that arrives while the channel is idle is dropped. It causes no write and no flag change.
- R12: While `adc_en_i` is low the channel is forced idle with its index cleared. Samples are dropped without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | ADDR_W | Buffer start byte address (bit 0 ignored) |
| cfg_len_i | input | SIZE_W | Buffer length in samples |
| cfg_wrap_i | input | 1 | Mode: 0 linear, 1 circular |
| chan_rst_i | input | 1 | Channel reset pulse |
| chan_load_i | input | 1 | Channel start pulse |
| adc_en_i | input | 1 | ADC enabled |
| smp_valid_i | input | 1 | Sample valid pulse |
| smp_data_i | input | DATA_W | Sample value |
| flag_clr_i | input | 3 | Write-one-to-clear: bit 0 half, bit 1 full, bit 2 overflow |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| cur_addr_o | output | ADDR_W | Next slot address |
| flag_half_o | output | 1 | Lower half filled |
| flag_full_o | output | 1 | Buffer filled |
| flag_ovf_o | output | 1 | Sample after a finished linear pass |

## Verification
The bench sweeps every length from 1 to 9 in both modes, using an even start address, an odd one and one near the top of the address space. This exposes several kinds of error:
- A half-point rounded the wrong way, or one that fires for len=1, sets the half flag one sample early or late.
- A linear pass that is one slot too long shows up as an extra write where the bench expects overflow.
- A circular pointer that wraps late writes past the buffer end.

Clear pulses are mixed in at regular intervals, some in the same cycle as a flag event, so a design that lets a clear win over a set is caught. The bench also fires a load in the middle of a run, feeds samples while the channel is idle, and drops `adc_en_i` during a linear pass; a design that restarts, writes or flags overflow in these cases fails the checks.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } chan_state_e;

  localparam int unsigned FLAG_HALF = 0;
  localparam int unsigned FLAG_FULL = 1;
  localparam int unsigned FLAG_OVF  = 2;
  localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/adc_dma_ctrl.sv
module adc_dma_ctrl
  import adc_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        chan_rst_i,
  input  logic        chan_load_i,
  input  logic        adc_en_i,
  input  logic        smp_valid_i,
  input  logic        len_nz_i,
  input  logic        last_i,
  input  logic        wrap_i,
  output chan_state_e state_o,
  output logic        clear_o,
  output logic        capture_o,
  output logic        accept_o,
  output logic        ovf_evt_o
);
  chan_state_e state_q, state_d;
  logic halt_w;

  assign halt_w    = chan_rst_i | ~adc_en_i;
  assign clear_o   = halt_w;
  assign capture_o = ~halt_w & chan_load_i & (state_q == ST_IDLE) & len_nz_i;
  assign accept_o  = ~halt_w & smp_valid_i & (state_q == ST_RUN);
  assign ovf_evt_o = ~halt_w & smp_valid_i & (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    if (halt_w)                           state_d = ST_IDLE;
    else if (capture_o)                   state_d = ST_RUN;
    else if (accept_o && last_i && !wrap_i) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/adc_dma_addr.sv
module adc_dma_addr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_len_i,
  input  logic              cfg_wrap_i,
  output logic              wrap_o,
  output logic              last_o,
  output logic              half_hit_o,
  output logic              full_hit_o,
  output logic [ADDR_W-1:0] slot_addr_o
);
  localparam int unsigned PAD_W = ADDR_W - SIZE_W - 1;

  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] len_q, idx_q;
  logic              wrap_q;
  logic [SIZE_W:0]   idx_nxt_w, half_pt_w;
  logic [ADDR_W-1:0] off_w;

  assign idx_nxt_w  = {1'b0, idx_q} + 1'b1;
  assign half_pt_w  = {2'b00, len_q[SIZE_W-1:1]};
  assign last_o     = (idx_nxt_w == {1'b0, len_q});
  assign half_hit_o = accept_i & (idx_nxt_w == half_pt_w);
  assign full_hit_o = accept_i & last_o;

  // byte offset of sample slot: 2 * index
  assign off_w       = {{PAD_W{1'b0}}, idx_q, 1'b0};
  assign slot_addr_o = base_q + off_w;
  assign wrap_o      = wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clear_i) begin
      idx_q <= '0;
    end else if (capture_i) begin
      base_q <= {cfg_base_i[ADDR_W-1:1], 1'b0};
      len_q  <= cfg_len_i;
      wrap_q <= cfg_wrap_i;
      idx_q  <= '0;
    end else if (accept_i) begin
      // linear end parks index at len; circular end returns to 0
      if (last_o && wrap_q) idx_q <= '0;
      else                  idx_q <= idx_nxt_w[SIZE_W-1:0];
    end
  end
endmodule

// File: rtl/adc_dma_flags.sv
module adc_dma_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[g] | (q & ~clr_i[g]); // set wins
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/adc_dma_writer.sv
module adc_dma_writer
  import adc_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SIZE_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_len_i,
  input  logic              cfg_wrap_i,
  input  logic              chan_rst_i,
  input  logic              chan_load_i,
  input  logic              adc_en_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [2:0]        flag_clr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              flag_half_o,
  output logic              flag_full_o,
  output logic              flag_ovf_o
);
  chan_state_e          state_w;
  logic                 clear_w, capture_w, accept_w, ovf_evt_w;
  logic                 wrap_w, last_w, half_hit_w, full_hit_w;
  logic [ADDR_W-1:0]    slot_addr_w;
  logic [NUM_FLAGS-1:0] flag_set_w, flag_w;

  adc_dma_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_rst_i  (chan_rst_i),
    .chan_load_i (chan_load_i),
    .adc_en_i    (adc_en_i),
    .smp_valid_i (smp_valid_i),
    .len_nz_i    (cfg_len_i != '0),
    .last_i      (last_w),
    .wrap_i      (wrap_w),
    .state_o     (state_w),
    .clear_o     (clear_w),
    .capture_o   (capture_w),
    .accept_o    (accept_w),
    .ovf_evt_o   (ovf_evt_w)
  );

  adc_dma_addr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_w),
    .capture_i   (capture_w),
    .accept_i    (accept_w),
    .cfg_base_i  (cfg_base_i),
    .cfg_len_i   (cfg_len_i),
    .cfg_wrap_i  (cfg_wrap_i),
    .wrap_o      (wrap_w),
    .last_o      (last_w),
    .half_hit_o  (half_hit_w),
    .full_hit_o  (full_hit_w),
    .slot_addr_o (slot_addr_w)
  );

  always_comb begin
    flag_set_w            = '0;
    flag_set_w[FLAG_HALF] = half_hit_w;
    flag_set_w[FLAG_FULL] = full_hit_w;
    flag_set_w[FLAG_OVF]  = ovf_evt_w;
  end

  adc_dma_flags #(.N(NUM_FLAGS)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set_w),
    .clr_i  (flag_clr_i),
    .flag_o (flag_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= accept_w;
      if (accept_w) begin
        mem_addr_o  <= slot_addr_w;
        mem_wdata_o <= smp_data_i;
      end
    end
  end

  assign cur_addr_o  = slot_addr_w;
  assign flag_half_o = flag_w[FLAG_HALF];
  assign flag_full_o = flag_w[FLAG_FULL];
  assign flag_ovf_o  = flag_w[FLAG_OVF];
endmodule

// File: rtl/adc_dma_writer_chk.sv
module adc_dma_writer_chk
  import adc_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chan_rst_i,
  input logic              adc_en_i,
  input logic              smp_valid_i,
  input logic [2:0]        flag_clr_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              flag_half_o,
  input logic              flag_full_o,
  input logic              flag_ovf_o,
  input chan_state_e       state_i,
  input logic              wrap_i,
  input logic              last_i
);
  a_r1_addr_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[0]);

  a_r11_write_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(state_i == ST_RUN));

  a_r2_chan_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> (state_i == ST_IDLE) && !mem_we_o);

  a_r12_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_en_i |=> state_i == ST_IDLE);

  a_r9_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && smp_valid_i && adc_en_i && !chan_rst_i && !last_i)
    |=> (cur_addr_o - $past(cur_addr_o)) == ADDR_W'(2));

  a_r8_no_ovf_circular: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_ovf_o) |-> !wrap_i);

  a_r10_half_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_half_o && !flag_clr_i[0] |=> flag_half_o);

  a_r10_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_full_o && !flag_clr_i[1] |=> flag_full_o);

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_ovf_o && !flag_clr_i[2] |=> flag_ovf_o);
endmodule

bind adc_dma_writer adc_dma_writer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_rst_i  (chan_rst_i),
  .adc_en_i    (adc_en_i),
  .smp_valid_i (smp_valid_i),
  .flag_clr_i  (flag_clr_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .cur_addr_o  (cur_addr_o),
  .flag_half_o (flag_half_o),
  .flag_full_o (flag_full_o),
  .flag_ovf_o  (flag_ovf_o),
  .state_i     (state_w),
  .wrap_i      (wrap_w),
  .last_i      (last_w)
);

// File: tb/test_adc_dma_writer.sv
`timescale 1ns/1ps
module test_adc_dma_writer;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_len = '0;
  logic          cfg_wrap = 1'b0;
  logic          chan_rst = 1'b0, chan_load = 1'b0, adc_en = 1'b0, smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [2:0]    flag_clr = '0;
  logic          mem_we, f_half, f_full, f_ovf;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  adc_dma_writer #(.ADDR_W(AW), .SIZE_W(SW), .DATA_W(DW)) i_adc_dma_writer (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_base_i(cfg_base), .cfg_len_i(cfg_len),
    .cfg_wrap_i(cfg_wrap), .chan_rst_i(chan_rst), .chan_load_i(chan_load),
    .adc_en_i(adc_en), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .flag_clr_i(flag_clr), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .cur_addr_o(cur_addr), .flag_half_o(f_half),
    .flag_full_o(f_full), .flag_ovf_o(f_ovf)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  // model: 0 idle, 1 running, 2 stopped
  int m_st = 0, m_idx = 0, m_len = 0, m_base = 0;
  bit m_wrap = 0, m_half = 0, m_full = 0, m_ovf = 0;

  task automatic chk(input bit ok, input string req, input string ctx, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic step(input bit v, input int d, input bit ld, input bit rs, input bit en,
                      input bit [2:0] clr, input int b, input int l, input bit w, input string ctx);
    bit halt, ev_h, ev_f, ev_o, e_we;
    int e_addr;
    smp_valid = v; smp_data = DW'(d); chan_load = ld; chan_rst = rs; adc_en = en;
    flag_clr = clr; cfg_base = AW'(b); cfg_len = SW'(l); cfg_wrap = w;
    @(posedge clk); #1;
    smp_valid = 0; chan_load = 0; chan_rst = 0; flag_clr = '0;
    halt = rs || !en; ev_h = 0; ev_f = 0; ev_o = 0; e_we = 0; e_addr = 0;
    if (halt) begin
      m_st = 0; m_idx = 0;
    end else if (m_st == 0 && ld && l != 0) begin
      m_st = 1; m_idx = 0; m_base = b & 'hFFFE; m_len = l; m_wrap = w;
    end else if (m_st == 1 && v) begin
      e_we = 1; e_addr = (m_base + 2 * m_idx) & 'hFFFF;
      if (m_idx + 1 == m_len / 2) ev_h = 1;
      if (m_idx + 1 == m_len) begin
        ev_f = 1;
        if (m_wrap) m_idx = 0;
        else begin m_idx = m_len; m_st = 2; end
      end else m_idx++;
    end else if (m_st == 2 && v) ev_o = 1;
    m_half = ev_h | (m_half & !clr[0]);
    m_full = ev_f | (m_full & !clr[1]);
    m_ovf  = ev_o | (m_ovf & !clr[2]);
    chk(mem_we == e_we, "R6", ctx, mem_we, e_we);
    if (e_we) begin
      chk(mem_addr == AW'(e_addr), "R1", ctx, mem_addr, e_addr);
      chk(mem_wdata == DW'(d), "R1", ctx, mem_wdata, d);
    end
    chk(cur_addr == AW'(m_base + 2 * m_idx), "R9", ctx, cur_addr, (m_base + 2 * m_idx) & 'hFFFF);
    chk(f_half == m_half, "R4", ctx, f_half, m_half);
    chk(f_full == m_full, "R5", ctx, f_full, m_full);
    chk(f_ovf == m_ovf, "R7", ctx, f_ovf, m_ovf);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bases[3] = '{'h0100, 'h1233, 'hFFF0};
    int sn = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(mem_we == 0 && cur_addr == 0 && !f_half && !f_full && !f_ovf,
        "R2", "async reset state", {mem_we, f_half, f_full, f_ovf}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    for (int w = 0; w < 2; w++) begin
      for (int l = 1; l <= 9; l++) begin
        for (int bi = 0; bi < 3; bi++) begin
          step(0, 0, 0, 1, 1, 3'b111, bases[bi], l, w[0], "R2 channel reset");
          chk(cur_addr == AW'(m_base), "R2", "ptr after reset", cur_addr, m_base);
          step(1, sn++, 0, 0, 1, 0, bases[bi], l, w[0], "R11 idle sample dropped");
          step(0, 0, 1, 0, 1, 0, bases[bi], l, w[0], "R3 load");
          chk(cur_addr == AW'(bases[bi] & 'hFFFE), "R3", "ptr after load", cur_addr,
              bases[bi] & 'hFFFE);
          for (int k = 0; k < (w ? 2 * l + 3 : l + 3); k++) begin
            step(1, sn++, k == 1, 0, 1, (k % 4 == 3) ? 3'b111 : 3'b000,
                 bases[bi] + 6, l + 1, ~w[0], w ? "R8 circular pass R10" : "R6 linear pass R10");
          end
          step(0, 0, 0, 0, 1, 3'b111, bases[bi], l, w[0], "R10 clear all");
        end
      end
    end

    // adc disable during a linear pass
    step(0, 0, 0, 1, 1, 0, 'h0400, 4, 0, "R12 prep reset");
    step(0, 0, 1, 0, 1, 0, 'h0400, 4, 0, "R12 load");
    step(1, 'hA5, 0, 0, 1, 0, 'h0400, 4, 0, "R12 sample");
    step(1, 'h5A, 0, 0, 0, 0, 'h0400, 4, 0, "R12 disabled sample");
    step(1, 'h77, 0, 0, 1, 0, 'h0400, 4, 0, "R12 re-enabled idle");
    chk(!f_ovf && !mem_we, "R12", "no ovf after disable", f_ovf, 0);
    step(0, 0, 1, 0, 0, 0, 'h0400, 4, 0, "R3 load while disabled");
    step(1, 'h11, 0, 0, 1, 0, 'h0400, 4, 0, "R3 still idle");
    // zero length load ignored
    step(0, 0, 1, 0, 1, 0, 'h0400, 0, 0, "R3 zero length load");
    step(1, 'h22, 0, 0, 1, 0, 'h0400, 0, 0, "R3 zero length idle");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule